// File: doc/BRIEF.md
# Two-Layer Windowed Pixel Blender

This block sits behind a raster timing generator and builds the final RGB colour of each screen position from two stacked layers and a background colour. The timing generator presents one raster position per cycle, in coordinates that count the sync and back-porch intervals. Each layer owns a rectangular window in those same coordinates. Inside its window, an enabled layer draws its pixel from its own valid/ready stream. Everywhere else, and whenever the layer is switched off, it shows a fixed 32-bit ARGB default colour instead.

Each stream word is widened from one of eight storage formats to 8-bit alpha, red, green and blue. Layer 1 is mixed onto the background, and layer 2 is then mixed onto that result. The mixing weights come from the layer's 8-bit constant alpha, optionally scaled by the pixel's own alpha. The blended colour appears one cycle after its position, with a valid flag.

Top module: `lyrblend_top`

## Requirements
- R1: A layer covers position (x, y) when hstart <= x <= hstop and vstart <= y <= vstop, bounds included. With a porch-inclusive raster, hstart is the summed sync and back-porch count plus 1 and hstop is that sum plus the width; the vertical bounds follow the same rule.
- R2: A layer's ready output is high in a cycle exactly when pos_valid is high, the layer's enable is 1 and the position lies inside its window. In all other cycles it is low, and no word is taken from the stream.
- R3: When a layer is disabled, or the position lies outside its window, the layer's source colour is its default colour. Bits [31:24] of the default colour are alpha, [23:16] red, [15:8] green and [7:0] blue.
- R4: When ready is high but the stream's valid input is low, the layer falls back to its default colour for that position.
- R5: The stream word is widened according to a 3-bit format code. Short channels are widened by repeating their high bits below themselves, and the alpha of formats without alpha is 0xFF. The codes are:
  - 0: ARGB 8:8:8:8 in bits [31:0].
  - 1: RGB 8:8:8 in bits [23:0].
  - 2: RGB 5:6:5 in bits [15:0].
  - 3: ARGB 1:5:5:5 in bits [15:0], where a set alpha bit gives 0xFF and a clear one gives 0x00.
  - 4: ARGB 4:4:4:4 in bits [15:0].
  - 5: 8-bit luminance in bits [7:0], copied to red, green and blue.
  - 6: alpha in bits [7:4] and luminance in bits [3:0].
  - 7: alpha in bits [15:8] and luminance in bits [7:0].
- R6: Each layer has two 3-bit blend-factor selects.
  - First factor: code 6 (3'b110) gives f1 = (pa*ca+127)/255, where pa is the pixel alpha and ca the constant alpha. Every other code (4 is the usual one) gives f1 = ca.
  - Second factor: code 7 (3'b111) gives f2 = 255 - (pa*ca+127)/255. Every other code (5 is the usual one) gives f2 = 255 - ca.
- R7: Each output channel is min(255, (src*f1 + dst*f2 + 127)/255), using integer division.
- R8: Layer 1 is mixed with the 24-bit background colour (red in [23:16]), and layer 2 is mixed with the result of that first mix.
- R9: out_valid equals pos_valid delayed by one cycle, and out_rgb in that cycle is the colour for that position. When pos_valid is low, out_rgb keeps its previous value.
- R10: During reset, out_valid and out_rgb are 0.
- R11: When layer 2 has constant alpha 0xFF with factor codes 4 and 5, the output equals layer 2's widened source colour, whatever layer 1 and the background hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| pos_valid | input | 1 | A raster position is presented this cycle |
| pos_x | input | CW | Porch-inclusive column |
| pos_y | input | CW | Porch-inclusive row |
| bg_rgb | input | 24 | Background colour |
| l1_en | input | 1 | Layer 1 enable |
| l1_fmt | input | 3 | Layer 1 format code |
| l1_calpha | input | 8 | Layer 1 constant alpha |
| l1_bf1 | input | 3 | Layer 1 first blend factor select |
| l1_bf2 | input | 3 | Layer 1 second blend factor select |
| l1_dflt | input | 32 | Layer 1 default ARGB colour |
| l1_hstart | input | CW | Layer 1 window first column |
| l1_hstop | input | CW | Layer 1 window last column |
| l1_vstart | input | CW | Layer 1 window first row |
| l1_vstop | input | CW | Layer 1 window last row |
| l1_pix | input | 32 | Layer 1 stream word |
| l1_valid | input | 1 | Layer 1 stream word valid |
| l1_ready | output | 1 | Layer 1 stream word taken |
| l2_en | input | 1 | Layer 2 enable |
| l2_fmt | input | 3 | Layer 2 format code |
| l2_calpha | input | 8 | Layer 2 constant alpha |
| l2_bf1 | input | 3 | Layer 2 first blend factor select |
| l2_bf2 | input | 3 | Layer 2 second blend factor select |
| l2_dflt | input | 32 | Layer 2 default ARGB colour |
| l2_hstart | input | CW | Layer 2 window first column |
| l2_hstop | input | CW | Layer 2 window last column |
| l2_vstart | input | CW | Layer 2 window first row |
| l2_vstop | input | CW | Layer 2 window last row |
| l2_pix | input | 32 | Layer 2 stream word |
| l2_valid | input | 1 | Layer 2 stream word valid |
| l2_ready | output | 1 | Layer 2 stream word taken |
| out_valid | output | 1 | Output colour valid |
| out_rgb | output | 24 | Blended colour, red in [23:16] |

## Verification
Some rules are checked by the assertions on every cycle:
- the ready of each layer only rises inside its enabled window while a position is presented;
- the one-cycle output timing holds, and the colour is held between positions;
- an underrun substitutes the default colour;
- a fully opaque top layer passes its widened colour straight through.

The arithmetic itself can only be shown by the bench's sweeps, which compare against expected values the bench computes on its own. These sweeps cover every format decode on varied words, the rounding and saturation of the mix across constant and pixel alpha, the stacking order of the two layers over the background, and the exact window edges.

// File: rtl/lyrblend_pkg.sv
package lyrblend_pkg;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;

  localparam logic [2:0] FMT_ARGB32 = 3'd0;
  localparam logic [2:0] FMT_RGB24  = 3'd1;
  localparam logic [2:0] FMT_RGB16  = 3'd2;
  localparam logic [2:0] FMT_A1RGB5 = 3'd3;
  localparam logic [2:0] FMT_ARGB4  = 3'd4;
  localparam logic [2:0] FMT_LUM8   = 3'd5;
  localparam logic [2:0] FMT_A4L4   = 3'd6;
  localparam logic [2:0] FMT_A8L8   = 3'd7;

  localparam logic [2:0] BF1_SCALED = 3'b110;
  localparam logic [2:0] BF2_SCALED = 3'b111;

  // Widen short channels by repeating their top bits below them.
  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction

  function automatic argb_t expand_pixel(input logic [2:0] fmt, input logic [31:0] d);
    argb_t e;
    e = '0;
    case (fmt)
      FMT_ARGB32: e = argb_t'(d);
      FMT_RGB24:  e = '{a: 8'hFF, r: d[23:16], g: d[15:8], b: d[7:0]};
      FMT_RGB16:  e = '{a: 8'hFF, r: widen5(d[15:11]), g: widen6(d[10:5]), b: widen5(d[4:0])};
      FMT_A1RGB5: e = '{a: {8{d[15]}}, r: widen5(d[14:10]), g: widen5(d[9:5]), b: widen5(d[4:0])};
      FMT_ARGB4:  e = '{a: widen4(d[15:12]), r: widen4(d[11:8]), g: widen4(d[7:4]), b: widen4(d[3:0])};
      FMT_LUM8:   e = '{a: 8'hFF, r: d[7:0], g: d[7:0], b: d[7:0]};
      FMT_A4L4:   e = '{a: widen4(d[7:4]), r: widen4(d[3:0]), g: widen4(d[3:0]), b: widen4(d[3:0])};
      FMT_A8L8:   e = '{a: d[15:8], r: d[7:0], g: d[7:0], b: d[7:0]};
      default:    e = '0;
    endcase
    return e;
  endfunction

  // Rounded division of an 8x8 product by 255.
  function automatic logic [7:0] div255_round(input logic [15:0] p);
    logic [16:0] t;
    t = {1'b0, p} + 17'd127;
    return 8'(t / 17'd255);
  endfunction

  // One colour channel: weighted sum, rounded, divided by 255, saturated.
  function automatic logic [7:0] mix_channel(input logic [7:0] src, input logic [7:0] dst,
                                             input logic [7:0] f1, input logic [7:0] f2);
    logic [17:0] s;
    logic [17:0] q;
    s = 18'(src) * 18'(f1) + 18'(dst) * 18'(f2) + 18'd127;
    q = s / 18'd255;
    return (q > 18'd255) ? 8'hFF : q[7:0];
  endfunction

endpackage

// File: rtl/lyrblend_layer_src.sv
module lyrblend_layer_src
  import lyrblend_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          pos_valid,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] pos_y,
  input  logic          en,
  input  logic [2:0]    fmt,
  input  logic [31:0]   dflt,
  input  logic [CW-1:0] hstart,
  input  logic [CW-1:0] hstop,
  input  logic [CW-1:0] vstart,
  input  logic [CW-1:0] vstop,
  input  logic [31:0]   pix,
  input  logic          pix_valid,
  output logic          ready,
  output logic          take,
  output argb_t         src
);

  logic in_h;
  logic in_v;
  logic in_win;

  assign in_h   = (pos_x >= hstart) && (pos_x <= hstop);
  assign in_v   = (pos_y >= vstart) && (pos_y <= vstop);
  assign in_win = in_h && in_v;

  assign ready  = pos_valid && en && in_win;
  assign take   = ready && pix_valid;
  assign src    = take ? expand_pixel(fmt, pix) : argb_t'(dflt);

endmodule

// File: rtl/lyrblend_mix.sv
module lyrblend_mix
  import lyrblend_pkg::*;
#(
  parameter int NCH = 3
) (
  input  argb_t           upper,
  input  logic [8*NCH-1:0] lower,
  input  logic [7:0]      calpha,
  input  logic [2:0]      bf1,
  input  logic [2:0]      bf2,
  output logic [8*NCH-1:0] result
);

  logic [7:0]       scaled_alpha;
  logic [7:0]       f_src;
  logic [7:0]       f_dst;
  logic [8*NCH-1:0] up_rgb;

  assign scaled_alpha = div255_round(16'(upper.a) * 16'(calpha));
  assign f_src        = (bf1 == BF1_SCALED) ? scaled_alpha : calpha;
  assign f_dst        = (bf2 == BF2_SCALED) ? (8'hFF - scaled_alpha) : (8'hFF - calpha);
  assign up_rgb       = 24'({upper.r, upper.g, upper.b});

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign result[8*c +: 8] = mix_channel(up_rgb[8*c +: 8], lower[8*c +: 8], f_src, f_dst);
  end

endmodule

// File: rtl/lyrblend_top.sv
module lyrblend_top
  import lyrblend_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pos_valid,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] pos_y,
  input  logic [23:0]   bg_rgb,
  input  logic          l1_en,
  input  logic [2:0]    l1_fmt,
  input  logic [7:0]    l1_calpha,
  input  logic [2:0]    l1_bf1,
  input  logic [2:0]    l1_bf2,
  input  logic [31:0]   l1_dflt,
  input  logic [CW-1:0] l1_hstart,
  input  logic [CW-1:0] l1_hstop,
  input  logic [CW-1:0] l1_vstart,
  input  logic [CW-1:0] l1_vstop,
  input  logic [31:0]   l1_pix,
  input  logic          l1_valid,
  output logic          l1_ready,
  input  logic          l2_en,
  input  logic [2:0]    l2_fmt,
  input  logic [7:0]    l2_calpha,
  input  logic [2:0]    l2_bf1,
  input  logic [2:0]    l2_bf2,
  input  logic [31:0]   l2_dflt,
  input  logic [CW-1:0] l2_hstart,
  input  logic [CW-1:0] l2_hstop,
  input  logic [CW-1:0] l2_vstart,
  input  logic [CW-1:0] l2_vstop,
  input  logic [31:0]   l2_pix,
  input  logic          l2_valid,
  output logic          l2_ready,
  output logic          out_valid,
  output logic [23:0]   out_rgb
);

  localparam int NLAYER = 2;
  localparam int RGBW   = 24;

  // Per-layer configuration gathered into arrays so one generate loop builds the stack.
  logic          en_a    [NLAYER];
  logic [2:0]    fmt_a   [NLAYER];
  logic [7:0]    ca_a    [NLAYER];
  logic [2:0]    bf1_a   [NLAYER];
  logic [2:0]    bf2_a   [NLAYER];
  logic [31:0]   dflt_a  [NLAYER];
  logic [CW-1:0] hs_a    [NLAYER];
  logic [CW-1:0] he_a    [NLAYER];
  logic [CW-1:0] vs_a    [NLAYER];
  logic [CW-1:0] ve_a    [NLAYER];
  logic [31:0]   pix_a   [NLAYER];
  logic          pv_a    [NLAYER];
  logic          rdy_a   [NLAYER];
  logic          take_a  [NLAYER];
  argb_t         src_a   [NLAYER];
  logic [RGBW-1:0] stage [NLAYER+1];

  assign en_a   = '{l1_en, l2_en};
  assign fmt_a  = '{l1_fmt, l2_fmt};
  assign ca_a   = '{l1_calpha, l2_calpha};
  assign bf1_a  = '{l1_bf1, l2_bf1};
  assign bf2_a  = '{l1_bf2, l2_bf2};
  assign dflt_a = '{l1_dflt, l2_dflt};
  assign hs_a   = '{l1_hstart, l2_hstart};
  assign he_a   = '{l1_hstop, l2_hstop};
  assign vs_a   = '{l1_vstart, l2_vstart};
  assign ve_a   = '{l1_vstop, l2_vstop};
  assign pix_a  = '{l1_pix, l2_pix};
  assign pv_a   = '{l1_valid, l2_valid};

  assign stage[0] = bg_rgb;

  for (genvar i = 0; i < NLAYER; i++) begin : g_layer
    lyrblend_layer_src #(.CW(CW)) u_src (
      .pos_valid (pos_valid),
      .pos_x     (pos_x),
      .pos_y     (pos_y),
      .en        (en_a[i]),
      .fmt       (fmt_a[i]),
      .dflt      (dflt_a[i]),
      .hstart    (hs_a[i]),
      .hstop     (he_a[i]),
      .vstart    (vs_a[i]),
      .vstop     (ve_a[i]),
      .pix       (pix_a[i]),
      .pix_valid (pv_a[i]),
      .ready     (rdy_a[i]),
      .take      (take_a[i]),
      .src       (src_a[i])
    );

    lyrblend_mix #(.NCH(RGBW / 8)) u_mix (
      .upper  (src_a[i]),
      .lower  (stage[i]),
      .calpha (ca_a[i]),
      .bf1    (bf1_a[i]),
      .bf2    (bf2_a[i]),
      .result (stage[i+1])
    );
  end

  // Named internal events for the checker.
  logic        l1_take;
  logic        l2_take;
  logic [31:0] l2_src_argb;
  logic [23:0] mixed_rgb;

  assign l1_take     = take_a[0];
  assign l2_take     = take_a[1];
  assign l2_src_argb = src_a[1];
  assign mixed_rgb   = stage[NLAYER];
  assign l1_ready    = rdy_a[0];
  assign l2_ready    = rdy_a[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= pos_valid;
      if (pos_valid) out_rgb <= mixed_rgb;
    end
  end

endmodule

// File: rtl/lyrblend_chk.sv
module lyrblend_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pos_valid,
  input logic [CW-1:0] pos_x,
  input logic [CW-1:0] pos_y,
  input logic          l1_en,
  input logic [CW-1:0] l1_hstart,
  input logic [CW-1:0] l1_hstop,
  input logic [CW-1:0] l1_vstart,
  input logic [CW-1:0] l1_vstop,
  input logic          l1_ready,
  input logic          l1_take,
  input logic          l2_en,
  input logic [CW-1:0] l2_hstart,
  input logic [CW-1:0] l2_hstop,
  input logic [CW-1:0] l2_vstart,
  input logic [CW-1:0] l2_vstop,
  input logic          l2_ready,
  input logic          l2_valid,
  input logic          l2_take,
  input logic [7:0]    l2_calpha,
  input logic [2:0]    l2_bf1,
  input logic [2:0]    l2_bf2,
  input logic [31:0]   l2_dflt,
  input logic [31:0]   l2_src_argb,
  input logic          out_valid,
  input logic [23:0]   out_rgb
);

  assert_l1_ready_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    l1_ready |-> (pos_valid && l1_en && pos_x >= l1_hstart && pos_x <= l1_hstop
                  && pos_y >= l1_vstart && pos_y <= l1_vstop));

  assert_l2_ready_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    l2_ready |-> (pos_valid && l2_en && pos_x >= l2_hstart && pos_x <= l2_hstop
                  && pos_y >= l2_vstart && pos_y <= l2_vstop));

  assert_take_needs_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_take || l2_take) |-> pos_valid);

  assert_underrun_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_ready && !l2_valid) |-> (l2_src_argb == l2_dflt));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid |=> out_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pos_valid |=> (!out_valid && $stable(out_rgb)));

  assert_opaque_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid && l2_calpha == 8'hFF && l2_bf1 == 3'b100 && l2_bf2 == 3'b101)
      |=> (out_rgb == $past(l2_src_argb[23:0])));

endmodule

bind lyrblend_top lyrblend_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pos_valid   (pos_valid),
  .pos_x       (pos_x),
  .pos_y       (pos_y),
  .l1_en       (l1_en),
  .l1_hstart   (l1_hstart),
  .l1_hstop    (l1_hstop),
  .l1_vstart   (l1_vstart),
  .l1_vstop    (l1_vstop),
  .l1_ready    (l1_ready),
  .l1_take     (l1_take),
  .l2_en       (l2_en),
  .l2_hstart   (l2_hstart),
  .l2_hstop    (l2_hstop),
  .l2_vstart   (l2_vstart),
  .l2_vstop    (l2_vstop),
  .l2_ready    (l2_ready),
  .l2_valid    (l2_valid),
  .l2_take     (l2_take),
  .l2_calpha   (l2_calpha),
  .l2_bf1      (l2_bf1),
  .l2_bf2      (l2_bf2),
  .l2_dflt     (l2_dflt),
  .l2_src_argb (l2_src_argb),
  .out_valid   (out_valid),
  .out_rgb     (out_rgb)
);

// File: tb/lyrblend_top_test.sv
`timescale 1ns/1ps
module lyrblend_top_test;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pos_valid = 1'b0;
  logic [CW-1:0] pos_x = '0;
  logic [CW-1:0] pos_y = '0;
  logic [23:0]   bg_rgb = 24'h204060;
  logic          l1_en = 1'b0, l2_en = 1'b0;
  logic [2:0]    l1_fmt = 3'd0, l2_fmt = 3'd0;
  logic [7:0]    l1_calpha = 8'hFF, l2_calpha = 8'hFF;
  logic [2:0]    l1_bf1 = 3'b100, l1_bf2 = 3'b101, l2_bf1 = 3'b100, l2_bf2 = 3'b101;
  logic [31:0]   l1_dflt = 32'hFF112233, l2_dflt = 32'h80C0A050;
  logic [CW-1:0] l1_hstart = 12'd3, l1_hstop = 12'd6, l1_vstart = 12'd2, l1_vstop = 12'd4;
  logic [CW-1:0] l2_hstart = 12'd5, l2_hstop = 12'd8, l2_vstart = 12'd3, l2_vstop = 12'd5;
  logic [31:0]   l1_pix = '0, l2_pix = '0;
  logic          l1_valid = 1'b0, l2_valid = 1'b0;
  logic          l1_ready, l2_ready, out_valid;
  logic [23:0]   out_rgb;

  int n_chk = 0;
  int n_bad = 0;
  logic [23:0] last_rgb = '0;

  always #5 clk = ~clk;

  lyrblend_top #(.CW(CW)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int w5(int v); return v * 8 + v / 4; endfunction
  function automatic int w6(int v); return v * 4 + v / 16; endfunction

  // Independent restatement of the format table (R5).
  function automatic logic [31:0] ref_expand(int fmt, logic [31:0] d);
    int a, r, g, b, x;
    x = int'(d);
    a = 255; r = 0; g = 0; b = 0;
    case (fmt)
      0: begin a = (x >> 24) & 255; r = (x >> 16) & 255; g = (x >> 8) & 255; b = x & 255; end
      1: begin r = (x >> 16) & 255; g = (x >> 8) & 255; b = x & 255; end
      2: begin r = w5((x >> 11) & 31); g = w6((x >> 5) & 63); b = w5(x & 31); end
      3: begin a = ((x >> 15) & 1) * 255; r = w5((x >> 10) & 31); g = w5((x >> 5) & 31); b = w5(x & 31); end
      4: begin a = ((x >> 12) & 15) * 17; r = ((x >> 8) & 15) * 17; g = ((x >> 4) & 15) * 17; b = (x & 15) * 17; end
      5: begin r = x & 255; g = r; b = r; end
      6: begin a = ((x >> 4) & 15) * 17; r = (x & 15) * 17; g = r; b = r; end
      default: begin a = (x >> 8) & 255; r = x & 255; g = r; b = r; end
    endcase
    return 32'((a << 24) | (r << 16) | (g << 8) | b);
  endfunction

  // Independent restatement of the factor and channel arithmetic (R6, R7).
  function automatic logic [23:0] ref_mix(logic [31:0] up, logic [23:0] low, int ca, int bf1, int bf2);
    int pa, prod, f1, f2, s, d, v;
    logic [23:0] res;
    pa = int'(up[31:24]);
    prod = (pa * ca + 127) / 255;
    f1 = (bf1 == 6) ? prod : ca;
    f2 = (bf2 == 7) ? 255 - prod : 255 - ca;
    res = '0;
    for (int c = 0; c < 3; c++) begin
      s = int'(up[8*c +: 8]);
      d = int'(low[8*c +: 8]);
      v = (s * f1 + d * f2 + 127) / 255;
      if (v > 255) v = 255;
      res[8*c +: 8] = 8'(v);
    end
    return res;
  endfunction

  // Stack order: layer 1 onto background, layer 2 onto that (R8).
  function automatic logic [23:0] ref_out(bit use1, logic [31:0] w1, bit use2, logic [31:0] w2);
    logic [31:0] s1, s2;
    logic [23:0] mid;
    s1 = use1 ? ref_expand(int'(l1_fmt), w1) : l1_dflt;
    mid = ref_mix(s1, bg_rgb, int'(l1_calpha), int'(l1_bf1), int'(l1_bf2));
    s2 = use2 ? ref_expand(int'(l2_fmt), w2) : l2_dflt;
    return ref_mix(s2, mid, int'(l2_calpha), int'(l2_bf1), int'(l2_bf2));
  endfunction

  task automatic step(input bit pv, input int x, input int y,
                      input logic [31:0] w1, input bit v1,
                      input logic [31:0] w2, input bit v2, input string req);
    bit win1, win2, er1, er2;
    logic [23:0] exp_rgb;
    @(negedge clk);
    pos_valid = pv; pos_x = CW'(x); pos_y = CW'(y);
    l1_pix = w1; l1_valid = v1; l2_pix = w2; l2_valid = v2;
    #1;
    win1 = (x >= int'(l1_hstart)) && (x <= int'(l1_hstop)) && (y >= int'(l1_vstart)) && (y <= int'(l1_vstop));
    win2 = (x >= int'(l2_hstart)) && (x <= int'(l2_hstop)) && (y >= int'(l2_vstart)) && (y <= int'(l2_vstop));
    er1 = pv && l1_en && win1;
    er2 = pv && l2_en && win2;
    check(l1_ready == er1, {req, " R1 R2 l1_ready"}, 32'(l1_ready), 32'(er1));
    check(l2_ready == er2, {req, " R1 R2 l2_ready"}, 32'(l2_ready), 32'(er2));
    exp_rgb = pv ? ref_out(er1 && v1, w1, er2 && v2, w2) : last_rgb;
    @(posedge clk);
    #2;
    check(out_valid == pv, {req, " R9 out_valid"}, 32'(out_valid), 32'(pv));
    check(out_rgb == exp_rgb, {req, " out_rgb"}, 32'(out_rgb), 32'(exp_rgb));
    last_rgb = exp_rgb;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] w;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid in reset", 32'(out_valid), 32'h0);
    check(out_rgb == 24'h0, "R10 out_rgb in reset", 32'(out_rgb), 32'h0);
    rst_n = 1'b1;

    // R5 and R11: every format on layer 2, fully opaque, layer 1 also live.
    l1_en = 1'b1; l2_en = 1'b1;
    for (int f = 0; f < 8; f++) begin
      l2_fmt = 3'(f);
      for (int k = 0; k < 16; k++) begin
        w = 32'h9E3779B9 * k ^ (32'(k) << 7) ^ 32'h0000_8421;
        step(1'b1, 6, 3, ~w, 1'b1, w, 1'b1, "R5 R11 format sweep");
      end
    end

    // R1 R2 R3: raster scan across both windows with partial alpha, then layer 2 disabled.
    l1_fmt = 3'd2; l2_fmt = 3'd0;
    l1_calpha = 8'hC0; l2_calpha = 8'h70;
    for (int pass = 0; pass < 2; pass++) begin
      l2_en = (pass == 0);
      for (int y = 0; y < 7; y++)
        for (int x = 0; x < 10; x++)
          step(1'b1, x, y, 32'(x * 2113 + y * 97), 1'b1, 32'h7F00_0000 | 32'(x * 41 + y * 3001), 1'b1,
               "R3 window scan");
    end
    l2_en = 1'b1;

    // R4: underrun inside both windows.
    step(1'b1, 5, 3, 32'h1234, 1'b0, 32'h5678, 1'b0, "R4 underrun both");
    step(1'b1, 6, 4, 32'h1234, 1'b1, 32'h5678, 1'b0, "R4 underrun layer2");

    // R9: idle positions hold the colour; ready stays low.
    step(1'b0, 5, 3, 32'hFFFF, 1'b1, 32'hFFFF, 1'b1, "R9 idle");
    step(1'b0, 0, 0, 32'h0, 1'b0, 32'h0, 1'b0, "R9 idle again");

    // R6 R7 R8: alpha sweep over factor modes, including saturating mixes.
    l1_fmt = 3'd0; l2_fmt = 3'd0;
    for (int m = 0; m < 3; m++) begin
      l1_bf1 = (m == 0) ? 3'b100 : 3'b110;
      l1_bf2 = (m == 1) ? 3'b111 : 3'b101;
      l2_bf1 = (m == 2) ? 3'b100 : 3'b110;
      l2_bf2 = (m == 0) ? 3'b101 : 3'b111;
      for (int ca = 0; ca < 256; ca += 17) begin
        l1_calpha = 8'(255 - ca); l2_calpha = 8'(ca);
        for (int p = 0; p < 4; p++)
          step(1'b1, 5, 4, {8'(p * 85), 24'hF08010 ^ 24'(ca * 257)}, 1'b1,
               {8'(255 - p * 60), 24'h10E0C0 ^ 24'(p * 4099)}, 1'b1, "R6 R7 R8 blend sweep");
      end
    end

    // R8: both constant alphas zero shows the background alone.
    l1_bf1 = 3'b100; l1_bf2 = 3'b101; l2_bf1 = 3'b100; l2_bf2 = 3'b101;
    l1_calpha = 8'h00; l2_calpha = 8'h00;
    step(1'b1, 5, 4, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b1, "R8 background only");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule